// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock Registers

This block is a real-time clock and calendar that answers on a synchronous byte bus. Eight byte registers sit at the top eight addresses of a 13-bit map. It keeps time in two copies. An internal packed-BCD counter chain (seconds up to century) advances once per second. That second is counted out from a stream of oscillator-rate enable pulses. A user-visible copy follows the counters one cycle behind, and it stops following them while software holds it.

A read hold freezes the visible copy so that software can read a consistent time while the internal count keeps going. A write hold also freezes the copy, and it routes bus writes into the copy. Clearing the write hold loads the new time into the counters and restarts the sub-second divider. The registers also carry an oscillator stop bit, a frequency-test bit that shows a 512 Hz square wave on the seconds LSB, and a read-only battery flag.

Register order, index = addr[2:0] with addr[12:3] all ones:
- 0 control: bit 7 write hold, bit 6 read hold, bits 5:0 century.
- 1 seconds: bit 7 stop.
- 2 minutes.
- 3 hours.
- 4 day of week: bit 7 battery flag, bit 6 frequency test.
- 5 date.
- 6 month.
- 7 year.

Top module: `bcd_rtc_regs`

## Requirements
- R1: A read takes place only when ce_n=0, ce2=1, oe_n=0, we_n=1 and addr is in 0x1FF8..0x1FFF, with register index addr[2:0] in the order control, seconds, minutes, hours, day, date, month, year. Outside a read, rdata is 0x00 and rdata_en is 0. A write needs ce_n=0, ce2=1, we_n=0 and takes effect at the clock edge.
- R2: After reset the time is century 0x20, year 0x00, month 0x01, date 0x01, day 0x01, 00:00:00, and all control bits are 0. The control register therefore reads 0x20.
- R3: Seconds advance once every TICKS_PER_SEC cycles with osc_tick high. Seconds and minutes roll from 0x59 to 0x00 and carry into the next field. Hours roll from 0x23 to 0x00. The visible copy shows a change one cycle after the internal counter changes.
- R4: At midnight the day of week steps, wrapping from 7 to 1. The date wraps after the last day of the month. February has 29 days when the year is a multiple of 4 and 28 otherwise. December wraps to January. Year 0x99 wraps to 0x00 and increments the century.
- R5: While the read hold (control bit 6) is 1, the visible registers keep their values and the internal count continues. One cycle after the bit is cleared, the visible registers show the current count.
- R6: A control write that clears the read hold leaves the century field unchanged. Otherwise, the century takes bits 5:0 of a control write only while the write hold is already 1 and the write keeps it at 1.
- R7: While the write hold (control bit 7) is 1, the visible copy is not refreshed, and writes to the time fields land in it. While the write hold is 0, writes to the time fields have no effect.
- R8: Clearing the write hold loads the visible time into the counters and restarts the divider, so the next second falls TICKS_PER_SEC pulses later. This load wins over a second tick that falls in the same cycle.
- R9: The stop bit (seconds bit 7) can be written at any time and reads back. While it is 1, the divider and all time fields stand still.
- R10: The frequency-test bit (day bit 6) can be written at any time. While it is 1 and the stop bit is 0, seconds bit 0 reads a square wave that toggles every TICKS_PER_SEC/1024 pulses and starts at 0 after a divider restart. While it is 0, bit 0 shows the real seconds LSB.
- R11: Day bit 7 reads as the inverse of batt_low, and writes have no effect on it.
- R12: Unused bits read 0: minutes bit 7, hours bits 7:6, day bits 5:3, date bits 7:6, month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_tick | input | 1 | Oscillator-rate enable, one pulse per oscillator period |
| batt_low | input | 1 | Backup supply exhausted |
| ce_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when not reading |
| rdata_en | output | 1 | High while a read of this block is active |

## Verification
The release of the write hold and the one-second tick can land in the same clock cycle. When they do, the load of the new time has to win, and the divider has to restart rather than also step the seconds. The bench provokes this by counting its own oscillator pulses from a known divider restart. It then issues the write that clears the hold together with the pulse that would complete the second. It judges the result by reading back exactly the written seconds value. It then checks that one pulse short of a full second later the value has not changed, and that one pulse after that it has advanced by one.

// File: rtl/rtc_pkg.sv
// Shared types and BCD helpers for the calendar clock registers.
// Assumes all time fields hold legal packed BCD values.
package rtc_pkg;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_SEC  = 3'd1;
    localparam logic [2:0] REG_MIN  = 3'd2;
    localparam logic [2:0] REG_HOUR = 3'd3;
    localparam logic [2:0] REG_DAY  = 3'd4;
    localparam logic [2:0] REG_DATE = 3'd5;
    localparam logic [2:0] REG_MON  = 3'd6;
    localparam logic [2:0] REG_YEAR = 3'd7;

    localparam rtc_time_t RTC_RESET = '{
        cent: 8'h20, year: 8'h00, month: 8'h01, date: 8'h01,
        day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00
    };

    // One BCD step: returns {wrapped, next value}
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] top,
                                            input logic [7:0] first);
        if (v == top)
            return {1'b1, first};
        if (v[3:0] == 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    // Multiple-of-four test on a two-digit BCD year
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last date of a month, in BCD
    function automatic logic [7:0] month_last(input logic [7:0] m,
                                              input logic [7:0] y);
        case (m)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
// Sub-second divider. Counts oscillator-rate enables and flags the last
// enable of each second. It also exposes the divider bit that toggles at
// 512 Hz.
// Assumes TICKS_PER_SEC is a power of two and at least 1024.
module rtc_tick_gen #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic run,
    input  logic restart,
    output logic sec_tick,
    output logic ft_wave
);
    localparam int CW               = $clog2(TICKS_PER_SEC);
    localparam int FT_BIT           = CW - 10;
    localparam logic [CW-1:0] LAST  = (CW)'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] ONE   = (CW)'(1);

    logic [CW-1:0] div_q;

    assign sec_tick = run && osc_tick && (div_q == LAST);
    assign ft_wave  = div_q[FT_BIT];

    // Divider count: restart wins, otherwise count enables while running
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (restart)
            div_q <= '0;
        else if (run && osc_tick)
            div_q <= (div_q == LAST) ? '0 : div_q + ONE;
    end

endmodule

// File: rtl/rtc_time_chain.sv
// Internal BCD counter chain from seconds up to century. It advances on
// the second tick, and a load replaces the whole time.
// Assumes loaded values are legal BCD within each field's range.
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now
);
    rtc_time_t  nxt;
    logic [8:0] step;
    logic       c_sec, c_min, c_hr, c_mon, c_yr;

    // Carry chain: compute the time one second ahead
    always_comb begin
        nxt   = now;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;
        step  = bcd_step(now.sec, 8'h59, 8'h00);
        c_sec = step[8];
        nxt.sec = step[7:0];
        if (c_sec) begin
            step    = bcd_step(now.min, 8'h59, 8'h00);
            c_min   = step[8];
            nxt.min = step[7:0];
        end
        if (c_min) begin
            step     = bcd_step(now.hour, 8'h23, 8'h00);
            c_hr     = step[8];
            nxt.hour = step[7:0];
        end
        if (c_hr) begin
            step     = bcd_step(now.day, 8'h07, 8'h01);
            nxt.day  = step[7:0];
            step     = bcd_step(now.date, month_last(now.month, now.year), 8'h01);
            c_mon    = step[8];
            nxt.date = step[7:0];
        end
        if (c_mon) begin
            step      = bcd_step(now.month, 8'h12, 8'h01);
            c_yr      = step[8];
            nxt.month = step[7:0];
        end
        if (c_yr) begin
            step     = bcd_step(now.year, 8'h99, 8'h00);
            nxt.year = step[7:0];
            if (step[8]) begin
                step     = bcd_step(now.cent, 8'h39, 8'h00);
                nxt.cent = step[7:0];
            end
        end
    end

    // Counter state: load has priority over the tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            now <= RTC_RESET;
        else if (load)
            now <= load_val;
        else if (sec_tick)
            now <= nxt;
    end

endmodule

// File: rtl/bcd_rtc_regs.sv
// Bus-facing register file of the calendar clock. It decodes the top
// eight byte addresses and keeps the visible time copy and the hold,
// stop and test bits. It instantiates the divider and the counter chain.
// Assumes one bus access per clock and software that writes legal BCD.
module bcd_rtc_regs
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int ADDR_W        = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              batt_low,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdata_en
);
    localparam int TAG_W = ADDR_W - 3;

    logic       sel, wr_en, rd_en;
    logic [2:0] idx;
    logic       r_q, w_q, stop_q, ft_q;
    logic       load, cent_we;
    logic       sec_tick, ft_wave;
    rtc_time_t  ext;
    rtc_time_t  int_now;
    logic [7:0] rd_mux;

    assign sel   = !ce_n && ce2 && (addr[ADDR_W-1:3] == {TAG_W{1'b1}});
    assign wr_en = sel && !we_n;
    assign rd_en = sel && !oe_n && we_n;
    assign idx   = addr[2:0];

    assign load    = wr_en && (idx == REG_CTRL) && w_q && !wdata[7];
    assign cent_we = wr_en && (idx == REG_CTRL) && w_q && wdata[7]
                     && !(r_q && !wdata[6]);

    rtc_tick_gen #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) i_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .run      (!stop_q),
        .restart  (load),
        .sec_tick (sec_tick),
        .ft_wave  (ft_wave)
    );

    rtc_time_chain i_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .load     (load),
        .load_val (ext),
        .now      (int_now)
    );

    // Hold, stop and test bits: written by any access to their register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= 1'b0;
            w_q    <= 1'b0;
            stop_q <= 1'b0;
            ft_q   <= 1'b0;
        end else if (wr_en) begin
            case (idx)
                REG_CTRL: begin
                    r_q <= wdata[6];
                    w_q <= wdata[7];
                end
                REG_SEC:  stop_q <= wdata[7];
                REG_DAY:  ft_q   <= wdata[6];
                default: ;
            endcase
        end
    end

    // Visible copy: mirrors the counters unless held; takes writes under write hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext <= RTC_RESET;
        end else if (!r_q && !w_q) begin
            ext <= int_now;
        end else if (w_q && wr_en) begin
            case (idx)
                REG_CTRL: if (cent_we) ext.cent <= {2'b00, wdata[5:0]};
                REG_SEC:  ext.sec   <= {1'b0, wdata[6:0]};
                REG_MIN:  ext.min   <= {1'b0, wdata[6:0]};
                REG_HOUR: ext.hour  <= {2'b00, wdata[5:0]};
                REG_DAY:  ext.day   <= {5'b00000, wdata[2:0]};
                REG_DATE: ext.date  <= {2'b00, wdata[5:0]};
                REG_MON:  ext.month <= {3'b000, wdata[4:0]};
                REG_YEAR: ext.year  <= wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer with status bits and the test wave merged in
    always_comb begin
        case (idx)
            REG_CTRL: rd_mux = {w_q, r_q, ext.cent[5:0]};
            REG_SEC:  rd_mux = {stop_q, ext.sec[6:1],
                                (ft_q && !stop_q) ? ft_wave : ext.sec[0]};
            REG_MIN:  rd_mux = {1'b0, ext.min[6:0]};
            REG_HOUR: rd_mux = {2'b00, ext.hour[5:0]};
            REG_DAY:  rd_mux = {!batt_low, ft_q, 3'b000, ext.day[2:0]};
            REG_DATE: rd_mux = {2'b00, ext.date[5:0]};
            REG_MON:  rd_mux = {3'b000, ext.month[4:0]};
            default:  rd_mux = ext.year;
        endcase
        rdata    = rd_en ? rd_mux : 8'h00;
        rdata_en = rd_en;
    end

endmodule

// File: rtl/rtc_regs_chk.sv
// Property checker for the calendar clock registers, bound to the top.
// Assumes the stimulus writes only legal BCD values.
module rtc_regs_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       wr_en,
    input logic [2:0] idx,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       batt_low,
    input logic       r_q,
    input logic       w_q,
    input logic       stop_q,
    input logic       load,
    input rtc_time_t  ext,
    input rtc_time_t  int_now
);

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == 8'h00)); // R1

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q && !w_q) |=> $stable(ext)); // R5

    AST_CENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == REG_CTRL && r_q && !wdata[6]) |=> $stable(ext.cent)); // R6

    AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q && !w_q) |=> (ext == $past(int_now))); // R7

    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (int_now == $past(ext))); // R8

    AST_STOP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !load) |=> $stable(int_now)); // R9

    AST_BATT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == REG_DAY) |-> (rdata[7] == !batt_low)); // R11

    AST_MONTH_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == REG_MON) |-> (rdata[7:5] == 3'b000)); // R12

endmodule

bind bcd_rtc_regs rtc_regs_chk i_rtc_regs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .idx      (idx),
    .wdata    (wdata),
    .rdata    (rdata),
    .batt_low (batt_low),
    .r_q      (r_q),
    .w_q      (w_q),
    .stop_q   (stop_q),
    .load     (load),
    .ext      (ext),
    .int_now  (int_now)
);

// File: tb/test_bcd_rtc_regs.sv
// Directed bench for bcd_rtc_regs: one task per scenario, each checking
// its own reads. It runs with 1024 oscillator pulses per second.
module test_bcd_rtc_regs;

    localparam int TPS = 1024;
    localparam logic [12:0] A_CTRL = 13'h1FF8;
    localparam logic [12:0] A_SEC  = 13'h1FF9;
    localparam logic [12:0] A_MIN  = 13'h1FFA;
    localparam logic [12:0] A_HOUR = 13'h1FFB;
    localparam logic [12:0] A_DAY  = 13'h1FFC;
    localparam logic [12:0] A_DATE = 13'h1FFD;
    localparam logic [12:0] A_MON  = 13'h1FFE;
    localparam logic [12:0] A_YEAR = 13'h1FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        batt_low = 1'b0;
    logic        ce_n = 1'b1;
    logic        ce2 = 1'b0;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bcd_rtc_regs #(.TICKS_PER_SEC(TPS)) i_bcd_rtc_regs (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .batt_low(batt_low),
        .ce_n(ce_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic tick);
        osc_tick = tick;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    task automatic bus_wr(input logic [12:0] a, input logic [7:0] d, input logic tick = 1'b0);
        ce_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; oe_n = 1'b1;
        addr = a; wdata = d; osc_tick = tick;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; osc_tick = 1'b0;
    endtask

    task automatic bus_rd(input logic [12:0] a, output logic [7:0] v);
        ce_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #2;
        v = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_chk(input string tag, input logic [12:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic set_time(input logic [7:0] ce, yr, mo, dt, dy, hr, mi, se);
        bus_wr(A_CTRL, 8'h80);
        bus_wr(A_CTRL, 8'h80 | ce);
        bus_wr(A_YEAR, yr);
        bus_wr(A_MON, mo);
        bus_wr(A_DATE, dt);
        bus_wr(A_DAY, dy);
        bus_wr(A_HOUR, hr);
        bus_wr(A_MIN, mi);
        bus_wr(A_SEC, se);
        bus_wr(A_CTRL, 8'h00);
        cyc(1'b0);
    endtask

    // R2 R11: reset values
    task automatic t_reset();
        rd_chk("R2 ctrl", A_CTRL, 8'h20);
        rd_chk("R2 sec", A_SEC, 8'h00);
        rd_chk("R2 min", A_MIN, 8'h00);
        rd_chk("R2 hour", A_HOUR, 8'h00);
        rd_chk("R2 R11 day", A_DAY, 8'h81);
        rd_chk("R2 date", A_DATE, 8'h01);
        rd_chk("R2 month", A_MON, 8'h01);
        rd_chk("R2 year", A_YEAR, 8'h00);
    endtask

    // R1: decode and read qualification
    task automatic t_decode();
        ce_n = 1'b0; ce2 = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = A_CTRL; #2;
        chk("R1 oe_n high", rdata, 8'h00);
        chk("R1 oe_n high en", {7'd0, rdata_en}, 8'h00);
        oe_n = 1'b0; ce2 = 1'b0; #2;
        chk("R1 ce2 low", rdata, 8'h00);
        ce2 = 1'b1; addr = 13'h0FF8; #2;
        chk("R1 outside map", rdata, 8'h00);
        addr = 13'h1FF7; #2;
        chk("R1 below window", rdata, 8'h00);
        addr = A_CTRL; #2;
        chk("R1 read active", rdata, 8'h20);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    // R3 R4: seconds carry through to century
    task automatic t_rollover();
        set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
        ticks(TPS - 1); cyc(1'b0);
        rd_chk("R3 one pulse short", A_SEC, 8'h58);
        ticks(1); cyc(1'b0);
        rd_chk("R3 sec step", A_SEC, 8'h59);
        ticks(TPS); cyc(1'b0);
        rd_chk("R4 century", A_CTRL, 8'h21);
        rd_chk("R4 year wrap", A_YEAR, 8'h00);
        rd_chk("R4 month wrap", A_MON, 8'h01);
        rd_chk("R4 date wrap", A_DATE, 8'h01);
        rd_chk("R4 day wrap", A_DAY, 8'h81);
        rd_chk("R3 hour wrap", A_HOUR, 8'h00);
        rd_chk("R3 min wrap", A_MIN, 8'h00);
        rd_chk("R3 sec wrap", A_SEC, 8'h00);
    endtask

    // R4: month lengths and leap years
    task automatic t_leap();
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        ticks(TPS); cyc(1'b0);
        rd_chk("R4 leap 29 date", A_DATE, 8'h29);
        rd_chk("R4 leap 29 month", A_MON, 8'h02);
        rd_chk("R4 day step", A_DAY, 8'h84);
        set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
        ticks(TPS); cyc(1'b0);
        rd_chk("R4 leap end date", A_DATE, 8'h01);
        rd_chk("R4 leap end month", A_MON, 8'h03);
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        ticks(TPS); cyc(1'b0);
        rd_chk("R4 common feb date", A_DATE, 8'h01);
        rd_chk("R4 common feb month", A_MON, 8'h03);
        set_time(8'h20, 8'h21, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
        ticks(TPS); cyc(1'b0);
        rd_chk("R4 april date", A_DATE, 8'h01);
        rd_chk("R4 april month", A_MON, 8'h05);
    endtask

    // R5 R6: read hold and century protection
    task automatic t_read_hold();
        set_time(8'h20, 8'h21, 8'h06, 8'h15, 8'h02, 8'h10, 8'h00, 8'h00);
        bus_wr(A_CTRL, 8'h40);
        ticks(2 * TPS); cyc(1'b0);
        rd_chk("R5 frozen sec", A_SEC, 8'h00);
        rd_chk("R5 hold bit", A_CTRL, 8'h60);
        bus_wr(A_CTRL, 8'h00);
        rd_chk("R6 century kept", A_CTRL, 8'h20);
        cyc(1'b0);
        rd_chk("R5 released sec", A_SEC, 8'h02);
        bus_wr(A_CTRL, 8'hC0);
        bus_wr(A_CTRL, 8'h85);
        rd_chk("R6 clear under write hold", A_CTRL, 8'hA0);
        bus_wr(A_CTRL, 8'h85);
        rd_chk("R6 century under write hold", A_CTRL, 8'h85);
        bus_wr(A_CTRL, 8'hA0);
        bus_wr(A_CTRL, 8'h00);
        cyc(1'b0);
    endtask

    // R7 R8: write hold, ignored writes, load on release
    task automatic t_write_hold();
        set_time(8'h20, 8'h22, 8'h03, 8'h10, 8'h04, 8'h12, 8'h00, 8'h00);
        bus_wr(A_MIN, 8'h33);
        cyc(1'b0);
        rd_chk("R7 write ignored", A_MIN, 8'h00);
        bus_wr(A_CTRL, 8'h80);
        ticks(TPS); cyc(1'b0);
        rd_chk("R7 not refreshed", A_SEC, 8'h00);
        bus_wr(A_MIN, 8'h45);
        rd_chk("R7 write lands", A_MIN, 8'h45);
        bus_wr(A_CTRL, 8'h00);
        cyc(1'b0);
        rd_chk("R8 loaded min", A_MIN, 8'h45);
        rd_chk("R8 loaded sec", A_SEC, 8'h00);
        ticks(TPS - 1); cyc(1'b0);
        rd_chk("R8 restart short", A_SEC, 8'h00);
        ticks(1); cyc(1'b0);
        rd_chk("R8 restart full", A_SEC, 8'h01);
    endtask

    // R8: release of write hold in the cycle of a second tick
    task automatic t_collide();
        set_time(8'h20, 8'h22, 8'h03, 8'h10, 8'h04, 8'h12, 8'h00, 8'h00);
        ticks(TPS - 1);
        bus_wr(A_CTRL, 8'h80);
        bus_wr(A_SEC, 8'h30);
        bus_wr(A_CTRL, 8'h00, 1'b1);
        cyc(1'b0);
        rd_chk("R8 load wins sec", A_SEC, 8'h30);
        rd_chk("R8 load wins min", A_MIN, 8'h00);
        ticks(TPS - 1); cyc(1'b0);
        rd_chk("R8 divider restarted", A_SEC, 8'h30);
        ticks(1); cyc(1'b0);
        rd_chk("R8 next second", A_SEC, 8'h31);
    endtask

    // R9: stop bit
    task automatic t_stop();
        set_time(8'h20, 8'h22, 8'h03, 8'h10, 8'h04, 8'h12, 8'h00, 8'h05);
        bus_wr(A_SEC, 8'h80);
        cyc(1'b0);
        rd_chk("R9 stop reads back", A_SEC, 8'h85);
        ticks(3 * TPS); cyc(1'b0);
        rd_chk("R9 stopped sec", A_SEC, 8'h85);
        rd_chk("R9 stopped min", A_MIN, 8'h00);
        bus_wr(A_SEC, 8'h00);
        ticks(TPS); cyc(1'b0);
        rd_chk("R9 running again", A_SEC, 8'h06);
    endtask

    // R10 R11: frequency test wave and battery flag
    task automatic t_ftest();
        set_time(8'h20, 8'h22, 8'h03, 8'h10, 8'h04, 8'h12, 8'h00, 8'h10);
        bus_wr(A_DAY, 8'h40);
        rd_chk("R10 wave phase 0", A_SEC, 8'h10);
        rd_chk("R10 ft reads back", A_DAY, 8'hC4);
        ticks(1);
        rd_chk("R10 wave phase 1", A_SEC, 8'h11);
        ticks(1);
        rd_chk("R10 wave phase 2", A_SEC, 8'h10);
        ticks(1);
        rd_chk("R10 wave phase 3", A_SEC, 8'h11);
        bus_wr(A_DAY, 8'h00);
        rd_chk("R10 real lsb", A_SEC, 8'h10);
        batt_low = 1'b1;
        rd_chk("R11 battery low", A_DAY, 8'h04);
        bus_wr(A_DAY, 8'h80);
        rd_chk("R11 flag not writable", A_DAY, 8'h04);
        batt_low = 1'b0;
        rd_chk("R11 battery good", A_DAY, 8'h84);
    endtask

    // R12: unused bits read 0
    task automatic t_pad();
        bus_wr(A_CTRL, 8'h80);
        bus_wr(A_SEC, 8'h7F);
        rd_chk("R12 sec", A_SEC, 8'h7F);
        bus_wr(A_MIN, 8'hFF);
        rd_chk("R12 min", A_MIN, 8'h7F);
        bus_wr(A_HOUR, 8'hFF);
        rd_chk("R12 hour", A_HOUR, 8'h3F);
        bus_wr(A_DATE, 8'hFF);
        rd_chk("R12 date", A_DATE, 8'h3F);
        bus_wr(A_MON, 8'hFF);
        rd_chk("R12 month", A_MON, 8'h1F);
        bus_wr(A_DAY, 8'hFF);
        rd_chk("R12 day", A_DAY, 8'hC7);
        set_time(8'h20, 8'h22, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
        rd_chk("R12 restored", A_DAY, 8'h81);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_rollover();
        t_leap();
        t_read_hold();
        t_write_hold();
        t_collide();
        t_stop();
        t_ftest();
        t_pad();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule